// File: doc/BRIEF.md
# Sum-Addressed Row Decoder

This block selects one of 2^n word lines from two n-bit operands, a base and an offset. The selected line is the one whose index equals their sum modulo 2^n. No adder is built. Each word line has its own comparator that checks whether the operand pair is consistent with that line's fixed index.

For each bit position, the comparator works out two carries:
- the carry-in that the position would need for its sum bit to equal the index bit;
- the carry-out that the position would produce if it were receiving that carry-in.

A line matches when these values agree at every bit boundary and the bottom position needs no carry-in. All comparators evaluate side by side, so the decode delay does not grow with a carry path.

A control module turns the enable into two strobes for the datapath. The datapath holds the comparator bank and an output stage. A parameter selects either a registered output stage (the default) or a purely combinational output.

Top module: `sadec_top`

## Requirements
- R1: With enable high, word line k is asserted if and only if k equals (base + offset) mod 2^ADDR_W. Bit k of `wordLine` is word line k.
- R2: With enable high, exactly one bit of `wordLine` is 1 for every operand pair.
- R3: With enable low, every bit of `wordLine` is 0, whatever the operands are.
- R4: When base + offset is 2^ADDR_W or more, the carry out of the top bit is dropped. The asserted line is the sum minus 2^ADDR_W; for example, 63 + 1 selects line 0 when ADDR_W = 6.
- R5: With REG_OUT = 1, `wordLine` shows the decode of the inputs present at the previous rising edge of `clk`. While `rstN` is low, `wordLine` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Decode enable; low forces all word lines low |
| baseIn | input | ADDR_W | Base operand |
| offsetIn | input | ADDR_W | Offset operand |
| wordLine | output | 2^ADDR_W | One-hot word-line vector |

## Verification
The assertions assume that the base, offset and enable inputs are stable and known at each rising clock edge. They also assume that enable is a clean level, since the registered checks compare each cycle's output with the previous edge's enable. The stimulus changes the inputs only on falling edges, and leaves them at defined values from reset release onward. Every operand pair for the default width is driven with enable high, including every wrapping pair. A further pass drives varied operands with enable low.

// File: rtl/sadec_pkg.sv
package sadec_pkg;
  typedef struct packed {
    logic decodeEn;
    logic clearOut;
  } sadecStrobes_t;
endpackage

// File: rtl/sadec_row_cmp.sv
module sadec_row_cmp #(
  parameter int ADDR_W  = 6,
  parameter int ROW_IDX = 0
) (
  input  logic [ADDR_W-1:0] baseIn,
  input  logic [ADDR_W-1:0] offsetIn,
  output logic              rowHit
);
  localparam logic [ADDR_W-1:0] ROW_K = ADDR_W'(ROW_IDX);

  logic [ADDR_W-1:0] halfSum;
  logic [ADDR_W-1:0] needCarry;
  logic [ADDR_W-1:0] makeCarry;
  logic [ADDR_W-2:0] linkOk;

  always_comb begin
    halfSum   = baseIn ^ offsetIn;
    // carry-in each bit must receive for its sum bit to equal ROW_K
    needCarry = halfSum ^ ROW_K;
    // carry-out each bit produces, given that carry-in
    makeCarry = (baseIn & offsetIn) | (halfSum & ~ROW_K);
  end

  genvar gi;
  generate
    for (gi = 1; gi < ADDR_W; gi++) begin : g_link
      assign linkOk[gi-1] = (makeCarry[gi-1] == needCarry[gi]);
    end
  endgenerate

  // bottom bit sees no carry-in; top carry-out is unused (wrap-around)
  assign rowHit = ~needCarry[0] & (&linkOk);
endmodule

// File: rtl/sadec_ctrl.sv
module sadec_ctrl
  import sadec_pkg::*;
(
  input  logic          enable,
  output sadecStrobes_t strobes
);
  always_comb begin
    strobes.decodeEn = enable;
    strobes.clearOut = ~enable;
  end
endmodule

// File: rtl/sadec_datapath.sv
module sadec_datapath
  import sadec_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  sadecStrobes_t         strobes,
  input  logic [ADDR_W-1:0]     baseIn,
  input  logic [ADDR_W-1:0]     offsetIn,
  output logic [(1<<ADDR_W)-1:0] wordLine
);
  localparam int ROWS = 1 << ADDR_W;

  logic [ROWS-1:0] rowHits;
  logic [ROWS-1:0] rowLines;

  genvar gr;
  generate
    for (gr = 0; gr < ROWS; gr++) begin : g_row
      sadec_row_cmp #(.ADDR_W(ADDR_W), .ROW_IDX(gr)) i_cmp (
        .baseIn  (baseIn),
        .offsetIn(offsetIn),
        .rowHit  (rowHits[gr])
      );
    end
  endgenerate

  assign rowLines = strobes.decodeEn ? rowHits : '0;

  generate
    if (REG_OUT) begin : g_reg
      logic [ROWS-1:0] lineQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 lineQ <= '0;
        else if (strobes.clearOut) lineQ <= '0;
        else                       lineQ <= rowLines;
      end
      assign wordLine = lineQ;

      // R3
      disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
        !strobes.decodeEn |=> (wordLine == '0));
      // R2
      single_line_chk: assert property (@(posedge clk) disable iff (!rstN)
        strobes.decodeEn |=> ($countones(wordLine) == 1));
    end else begin : g_comb
      assign wordLine = rowLines;

      // R3
      disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
        !strobes.decodeEn |-> (wordLine == '0));
      // R2
      single_line_chk: assert property (@(posedge clk) disable iff (!rstN)
        strobes.decodeEn |-> ($countones(wordLine) == 1));
    end
  endgenerate

  logic [ADDR_W-1:0] refSum;
  logic [ROWS-1:0]   refLine;
  always_comb begin
    refSum  = baseIn + offsetIn;
    refLine = ROWS'(1) << refSum;
  end

  // R1 R4
  sum_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.decodeEn |-> (rowHits == refLine));
  // R2
  bank_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rowHits));
endmodule

// File: rtl/sadec_top.sv
module sadec_top
  import sadec_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   enable,
  input  logic [ADDR_W-1:0]      baseIn,
  input  logic [ADDR_W-1:0]      offsetIn,
  output logic [(1<<ADDR_W)-1:0] wordLine
);
  sadecStrobes_t strobes;

  sadec_ctrl i_ctrl (
    .enable (enable),
    .strobes(strobes)
  );

  sadec_datapath #(.ADDR_W(ADDR_W), .REG_OUT(REG_OUT)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .baseIn  (baseIn),
    .offsetIn(offsetIn),
    .wordLine(wordLine)
  );

  // R5
  reset_clear_chk: assert property (@(posedge clk) !rstN |-> (wordLine == '0));
endmodule

// File: tb/test_sadec_top.sv
module test_sadec_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam int ROWS = 1 << ADDR_W;
  localparam int WATCHDOG = 20000;

  typedef struct {
    logic [ROWS-1:0] expLine;
    string           tag;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [ADDR_W-1:0] baseIn = '0;
  logic [ADDR_W-1:0] offsetIn = '0;
  logic [ROWS-1:0] wordLine;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 1'b0;
  item_t sb[$];

  sadec_top #(.ADDR_W(ADDR_W), .REG_OUT(1'b1)) i_sadec_top (
    .clk(clk), .rstN(rstN), .enable(enable),
    .baseIn(baseIn), .offsetIn(offsetIn), .wordLine(wordLine)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic check(string tag, logic [ROWS-1:0] act, logic [ROWS-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: apply at falling edge, queue expected result for the next edge
  task automatic drive(logic en, logic [ADDR_W-1:0] a, logic [ADDR_W-1:0] b);
    item_t it;
    int s;
    @(negedge clk);
    enable = en;
    baseIn = a;
    offsetIn = b;
    s = int'(a) + int'(b);
    if (!en) begin
      it.expLine = '0;
      it.tag = "R3";
    end else begin
      it.expLine = '0;
      it.expLine[s % ROWS] = 1'b1;
      it.tag = (s >= ROWS) ? "R4" : "R1";
    end
    sb.push_back(it);
  endtask

  // monitor: just after each rising edge, compare the registered output
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() != 0) begin
        item_t it;
        it = sb.pop_front();
        check(it.tag, wordLine, it.expLine);
        if (it.expLine != '0) begin
          total++;
          if ($countones(wordLine) != 1) begin
            bad++;
            $display("FAIL R2: actual ones=%0d expected ones=1", $countones(wordLine));
          end
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        total++;
        bad++;
        $display("FAIL watchdog: actual cycles=%0d expected below %0d", cycles, WATCHDOG);
        report();
      end
    end
  end

  initial begin
    enable = 1'b1;
    baseIn = 6'd5;
    offsetIn = 6'd9;
    repeat (3) @(posedge clk);
    #1;
    check("R5", wordLine, '0);   // held clear in reset despite enable
    @(negedge clk);
    rstN = 1'b1;
    enable = 1'b0;

    // R1 R2 R4: every operand pair with enable high
    for (int a = 0; a < ROWS; a++)
      for (int b = 0; b < ROWS; b++)
        drive(1'b1, ADDR_W'(a), ADDR_W'(b));

    // R3: operands ignored while disabled
    for (int k = 0; k < ROWS; k++)
      drive(1'b0, ADDR_W'(k * 7 + 3), ADDR_W'(k * 13 + 1));

    // R5: one-cycle latency, toggling enable between neighbours
    drive(1'b1, 6'd63, 6'd63);
    drive(1'b0, 6'd20, 6'd22);
    drive(1'b1, 6'd40, 6'd30);

    @(negedge clk);
    enable = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    report();
  end
endmodule